// File: doc/BRIEF.md
# Two-Stage Expiry Watchdog Timer

This block is a watchdog timer that sits behind a small word-wide register bus. A prescaler divides the core clock into a slow tick, and a down-counter steps once per tick. When the counter runs out, the block does not reset the system at once. The first run-out sets a sticky flag and, if enabled, pulses an event line so a handler can react. The counter then reloads and runs a second lap. If the flag is still set when that second lap runs out, the block raises a level reset request and latches a second-timeout flag.

Software keeps the system alive by writing to the reload location, which restarts the count from the programmed initial value. Software can also clear the first-stage flag, which arms the two-stage sequence again. A halt bit freezes the count. An external mask input lets the system keep the reset request off, for example during bring-up, while the count and the flags go on working. Reading the reload location returns the live count. The initial-value field refuses values too small to be useful.

Top module: `wdt2_top`

## Requirements
- R1: After reset, the halt bit (bit 11 at offset 4) reads 1. The count and the initial value both equal DEF_INIT. Both status words (offsets 2 and 3) read 0, and evt_o and rst_req_o are low.
- R2: While not halted, the count drops by one every PRESCALE clock cycles, counted from the last reload write.
- R3: A write of any data to offset 0 loads the count from the initial value and restarts the prescaler. A read of offset 0 returns the live count in bits 9:0, with the upper bits reading 0.
- R4: A write to offset 1 updates only the 10-bit initial value in bits 9:0, and bits 15:10 always read 0. A write whose bits 9:0 are 0 to 3 is ignored, and the old value stays.
- R5: While the halt bit is 1, the count holds its value.
- R6: A tick that finds the count at 0 is an expiry, and the count reloads on that same tick. For an initial value I, an expiry therefore falls (I+1)*PRESCALE cycles after a reload write. A first expiry sets bit 3 at offset 2.
- R7: A first expiry drives evt_o high for exactly one cycle when the enable bit (bit 13 at offset 5) is 1. evt_o stays low when that bit is 0, and on any later expiry.
- R8: An expiry while bit 3 at offset 2 is set sets the second-timeout flag (bit 1 at offset 3). rst_req_o is then high and stays high until the flag is cleared.
- R9: Status bits clear when written with 1, and writing 0 leaves them unchanged. Clearing bit 3 at offset 2 before the next expiry makes that expiry count as a first expiry again.
- R10: While reboot_mask_i is 1, rst_req_o stays low, but the count and the flags still update. When the mask drops with the flag set, rst_req_o rises.
- R11: An expiry while the second-timeout flag is set sets the boot-status flag (bit 2 at offset 3).
- R12: A reload write in the same cycle as an expiry wins. The count reloads, no flag changes, no event is raised, and the next expiry comes a full (I+1)*PRESCALE cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous hard reset |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 16 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| reboot_mask_i | input | 1 | 1 suppresses the reset request |
| evt_o | output | 1 | One-cycle event pulse on a first expiry |
| rst_req_o | output | 1 | Level reset request after a second expiry |

## Verification
The hardest case to reach from the ports is the collision of a reload write with the exact cycle of an expiry. Only one clock edge in each lap lets it happen. The bench reaches it by always restarting the prescaler with a reload write. It then counts (I+1)*PRESCALE-2 further edges and issues the next reload write so that it is captured on the expiry edge. The third-expiry boot flag and the masked reset request need a longer chain of uncleared laps. The bench tracks each expiry edge exactly so that every flag is sampled one cycle before and one cycle after its change.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;

  typedef enum logic [2:0] {
    RG_RELOAD = 3'd0,
    RG_INIT   = 3'd1,
    RG_STAT1  = 3'd2,
    RG_STAT2  = 3'd3,
    RG_CTRL   = 3'd4,
    RG_EVEN   = 3'd5
  } reg_sel_e;

  localparam int HALT_BIT   = 11;
  localparam int FIRST_BIT  = 3;
  localparam int SECOND_BIT = 1;
  localparam int BOOT_BIT   = 2;
  localparam int EVEN_BIT   = 13;
  localparam int MIN_INIT   = 4;

  // An initial value is accepted only at or above the floor.
  function automatic logic init_ok(input int unsigned v);
    return v >= MIN_INIT;
  endfunction

  // Cycles from a reload write to the expiry edge.
  function automatic int unsigned lap_cycles(input int unsigned init, input int unsigned div);
    return (init + 1) * div;
  endfunction

endpackage

// File: rtl/wdt2_prescaler.sv
module wdt2_prescaler #(
  parameter int PRESCALE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic tick_o
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PW-1:0] pre_q;

  assign tick_o = (pre_q == PW'(PRESCALE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (clear_i || tick_o) pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdt2_counter.sv
module wdt2_counter #(
  parameter int              CNT_W    = 10,
  parameter logic [CNT_W-1:0] DEF_INIT = 10'd20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             halt_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] init_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic step;

  assign step     = tick_i && !halt_i && !load_i;
  assign expire_o = step && (cnt_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_o <= DEF_INIT;
    else if (load_i)   cnt_o <= init_i;
    else if (expire_o) cnt_o <= init_i;
    else if (step)     cnt_o <= cnt_o - 1'b1;
  end
endmodule

// File: rtl/wdt2_status.sv
module wdt2_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic ev_en_i,
  input  logic clr_first_i,
  input  logic clr_second_i,
  input  logic clr_boot_i,
  output logic first_o,
  output logic second_o,
  output logic boot_o,
  output logic evt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_o  <= 1'b0;
      second_o <= 1'b0;
      boot_o   <= 1'b0;
      evt_o    <= 1'b0;
    end else begin
      evt_o <= expire_i && !first_o && ev_en_i;

      if (expire_i && !first_o) first_o <= 1'b1;
      else if (clr_first_i)     first_o <= 1'b0;

      if (expire_i && first_o)  second_o <= 1'b1;
      else if (clr_second_i)    second_o <= 1'b0;

      if (expire_i && second_o) boot_o <= 1'b1;
      else if (clr_boot_i)      boot_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt2_top.sv
module wdt2_top import wdt2_pkg::*; #(
  parameter int               PRESCALE = 4,
  parameter int               CNT_W    = 10,
  parameter int               DW       = 16,
  parameter logic [CNT_W-1:0] DEF_INIT = 10'd20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wr_i,
  output logic [DW-1:0] rdata_o,
  input  logic          reboot_mask_i,
  output logic          evt_o,
  output logic          rst_req_o
);
  logic             halt_q, ev_en_q;
  logic [CNT_W-1:0] init_q, cnt;
  logic             tick, expire;
  logic             first_q, second_q, boot_q;
  logic             wr_reload, wr_init, wr_stat1, wr_stat2, wr_ctrl, wr_even;
  logic             stat_wr;

  assign wr_reload = wr_i && (addr_i == RG_RELOAD);
  assign wr_init   = wr_i && (addr_i == RG_INIT);
  assign wr_stat1  = wr_i && (addr_i == RG_STAT1);
  assign wr_stat2  = wr_i && (addr_i == RG_STAT2);
  assign wr_ctrl   = wr_i && (addr_i == RG_CTRL);
  assign wr_even   = wr_i && (addr_i == RG_EVEN);
  assign stat_wr   = wr_stat1 || wr_stat2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q  <= 1'b1;
      ev_en_q <= 1'b0;
      init_q  <= DEF_INIT;
    end else begin
      if (wr_ctrl) halt_q  <= wdata_i[HALT_BIT];
      if (wr_even) ev_en_q <= wdata_i[EVEN_BIT];
      if (wr_init && init_ok(int'(wdata_i[CNT_W-1:0])))
        init_q <= wdata_i[CNT_W-1:0];
    end
  end

  wdt2_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (halt_q || wr_reload),
    .tick_o  (tick)
  );

  wdt2_counter #(.CNT_W(CNT_W), .DEF_INIT(DEF_INIT)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .halt_i   (halt_q),
    .load_i   (wr_reload),
    .init_i   (init_q),
    .cnt_o    (cnt),
    .expire_o (expire)
  );

  wdt2_status u_sts (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .expire_i     (expire),
    .ev_en_i      (ev_en_q),
    .clr_first_i  (wr_stat1 && wdata_i[FIRST_BIT]),
    .clr_second_i (wr_stat2 && wdata_i[SECOND_BIT]),
    .clr_boot_i   (wr_stat2 && wdata_i[BOOT_BIT]),
    .first_o      (first_q),
    .second_o     (second_q),
    .boot_o       (boot_q),
    .evt_o        (evt_o)
  );

  assign rst_req_o = second_q && !reboot_mask_i;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RG_RELOAD: rdata_o[CNT_W-1:0] = cnt;
      RG_INIT:   rdata_o[CNT_W-1:0] = init_q;
      RG_STAT1:  rdata_o[FIRST_BIT] = first_q;
      RG_STAT2: begin
        rdata_o[SECOND_BIT] = second_q;
        rdata_o[BOOT_BIT]   = boot_q;
      end
      RG_CTRL:   rdata_o[HALT_BIT]  = halt_q;
      RG_EVEN:   rdata_o[EVEN_BIT]  = ev_en_q;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt2_checker.sv
module wdt2_checker import wdt2_pkg::*; #(
  parameter int CNT_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] init_q,
  input logic             halt_q,
  input logic             wr_reload,
  input logic             stat_wr,
  input logic             expire,
  input logic             first_q,
  input logic             second_q,
  input logic             boot_q,
  input logic             evt_o,
  input logic             rst_req_o,
  input logic             reboot_mask_i
);
  a_r3_reload_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_reload |=> cnt == $past(init_q));

  a_r4_init_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q >= CNT_W'(MIN_INIT));

  a_r5_halt_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_q && !wr_reload) |=> $stable(cnt));

  a_r7_evt_marks_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> first_q);

  a_r8_second_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && first_q) |=> second_q);

  a_r10_req_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (second_q && !reboot_mask_i));

  a_r12_reload_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_reload && !stat_wr) |=> ($stable(first_q) && $stable(second_q) && $stable(boot_q) && !evt_o));
endmodule

bind wdt2_top wdt2_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cnt           (cnt),
  .init_q        (init_q),
  .halt_q        (halt_q),
  .wr_reload     (wr_reload),
  .stat_wr       (stat_wr),
  .expire        (expire),
  .first_q       (first_q),
  .second_q      (second_q),
  .boot_q        (boot_q),
  .evt_o         (evt_o),
  .rst_req_o     (rst_req_o),
  .reboot_mask_i (reboot_mask_i)
);

// File: tb/tb_wdt2_top.sv
module tb_wdt2_top;
  localparam int DIV  = 4;
  localparam int INIT = 5;
  localparam int LAP  = (INIT + 1) * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        wr = 1'b0;
  logic [15:0] rdata;
  logic        mask = 1'b0;
  logic        evt, rst_req;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  wdt2_top #(.PRESCALE(DIV), .CNT_W(10), .DW(16), .DEF_INIT(10'd20)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr),
    .rdata_o(rdata), .reboot_mask_i(mask), .evt_o(evt), .rst_req_o(rst_req)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd_reg(3'd4, d); chk("R1 halt after reset", d, 16'h0800);
    rd_reg(3'd0, d); chk("R1 count after reset", d, 16'd20);
    rd_reg(3'd1, d); chk("R1 init after reset", d, 16'd20);
    rd_reg(3'd2, d); chk("R1 stat1 after reset", d, 16'h0);
    rd_reg(3'd3, d); chk("R1 stat2 after reset", d, 16'h0);
    chk("R1 outputs after reset", {14'd0, evt, rst_req}, 16'h0);
  endtask

  task automatic t_init();
    logic [15:0] d;
    wr_reg(3'd1, 16'h0003); rd_reg(3'd1, d); chk("R4 value 3 ignored", d, 16'd20);
    wr_reg(3'd1, 16'hFC05); rd_reg(3'd1, d); chk("R4 only low field written", d, 16'h0005);
    wr_reg(3'd1, 16'h0000); rd_reg(3'd1, d); chk("R4 value 0 ignored", d, 16'h0005);
  endtask

  task automatic t_halt();
    logic [15:0] d;
    wr_reg(3'd0, 16'hABCD); rd_reg(3'd0, d); chk("R3 reload readback", d, INIT);
    wait_cyc(6 * DIV);      rd_reg(3'd0, d); chk("R5 halted count holds", d, INIT);
  endtask

  task automatic t_count();
    logic [15:0] d;
    wr_reg(3'd4, 16'h0000);
    wr_reg(3'd0, 16'h0000);
    wait_cyc(DIV);     rd_reg(3'd0, d); chk("R2 first decrement", d, INIT - 1);
    wait_cyc(DIV - 1); rd_reg(3'd0, d); chk("R2 holds between ticks", d, INIT - 1);
    wait_cyc(1);       rd_reg(3'd0, d); chk("R2 second decrement", d, INIT - 2);
  endtask

  // First, second and third expiry without service.
  task automatic t_laps();
    logic [15:0] d;
    wr_reg(3'd5, 16'h2000);
    wr_reg(3'd0, 16'h0000);
    wait_cyc(LAP - 1);
    rd_reg(3'd2, d); chk("R6 no flag before expiry", d, 16'h0);
    rd_reg(3'd0, d); chk("R6 count at zero", d, 16'h0);
    wait_cyc(1);
    rd_reg(3'd2, d); chk("R6 first flag set", d, 16'h0008);
    rd_reg(3'd0, d); chk("R6 reload on expiry", d, INIT);
    chk("R7 event pulse", {15'd0, evt}, 16'h1);
    wait_cyc(1);
    chk("R7 event one cycle", {15'd0, evt}, 16'h0);
    wait_cyc(LAP - 2);
    rd_reg(3'd3, d); chk("R8 no second flag yet", d, 16'h0);
    wait_cyc(1);
    rd_reg(3'd3, d); chk("R8 second flag set", d, 16'h0002);
    chk("R8 reset request", {15'd0, rst_req}, 16'h1);
    chk("R7 no event on second expiry", {15'd0, evt}, 16'h0);
    wait_cyc(10);
    chk("R8 request held", {15'd0, rst_req}, 16'h1);
    wait_cyc(LAP - 10);
    rd_reg(3'd3, d); chk("R11 boot flag set", d, 16'h0006);
    wr_reg(3'd3, 16'h0000); rd_reg(3'd3, d); chk("R9 write 0 keeps flags", d, 16'h0006);
    wr_reg(3'd3, 16'h0006); rd_reg(3'd3, d); chk("R9 stat2 cleared", d, 16'h0);
    chk("R9 request drops", {15'd0, rst_req}, 16'h0);
    wr_reg(3'd2, 16'h0008); rd_reg(3'd2, d); chk("R9 stat1 cleared", d, 16'h0);
  endtask

  task automatic t_restart();
    logic [15:0] d;
    wr_reg(3'd5, 16'h0000);
    wr_reg(3'd0, 16'h0000);
    wait_cyc(LAP);
    rd_reg(3'd2, d); chk("R6 first flag again", d, 16'h0008);
    chk("R7 no event when disabled", {15'd0, evt}, 16'h0);
    wr_reg(3'd2, 16'h0008);
    rd_reg(3'd2, d); chk("R9 first flag cleared", d, 16'h0);
    wait_cyc(LAP - 1);
    rd_reg(3'd2, d); chk("R9 restart gives first expiry", d, 16'h0008);
    rd_reg(3'd3, d); chk("R9 restart no second flag", d, 16'h0);
    wr_reg(3'd2, 16'h0008);
  endtask

  task automatic t_mask();
    logic [15:0] d;
    mask = 1'b1;
    wr_reg(3'd0, 16'h0000);
    wait_cyc(2 * LAP);
    rd_reg(3'd3, d); chk("R10 flag updates under mask", d, 16'h0002);
    chk("R10 request suppressed", {15'd0, rst_req}, 16'h0);
    mask = 1'b0;
    #1;
    chk("R10 request after unmask", {15'd0, rst_req}, 16'h1);
    wr_reg(3'd3, 16'h0006);
    wr_reg(3'd2, 16'h0008);
  endtask

  task automatic t_prio();
    logic [15:0] d;
    wr_reg(3'd5, 16'h2000);
    wr_reg(3'd0, 16'h0000);
    wait_cyc(LAP - 2);
    wr_reg(3'd0, 16'h0000);
    rd_reg(3'd2, d); chk("R12 collision sets no flag", d, 16'h0);
    rd_reg(3'd0, d); chk("R12 collision reloads", d, INIT);
    chk("R12 collision no event", {15'd0, evt}, 16'h0);
    wait_cyc(LAP - 1);
    rd_reg(3'd2, d); chk("R12 full lap before expiry", d, 16'h0);
    wait_cyc(1);
    rd_reg(3'd2, d); chk("R12 expiry after full lap", d, 16'h0008);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_init();
    t_halt();
    t_count();
    t_laps();
    t_restart();
    t_mask();
    t_prio();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end
endmodule